// File: doc/BRIEF.md
# Audio Output Stream Start Trigger

This block decides the exact frame in which an outgoing serial audio stream begins. A frame counter advances by one on every word-clock boundary and wraps to zero after a programmable period value. Software programs a start value. The block raises a single-cycle start pulse at the frame boundary where the counter takes that value, but only if every readiness condition holds at that moment. The downstream serializer uses the pulse to shift out the first buffered output word. Because of this, the first sample of the first output buffer always lines up with a known frame index.

There are three readiness conditions. First, at least one data pin must be set as an output. Second, the buffer size must be flagged valid and 32 bit-clock ticks must have passed since then. Third, when the channel masks select a channel that needs a memory fetch, two samples must already be preloaded. After the pulse the block holds a running state until software clears the enable. The bit clock and the word clock arrive as single-cycle strobes in the system clock domain. Every pin is a plain control or status level, and no data stream passes through the block.

Top module: `aout_start_trigger`

## Requirements
- R1: The frame counter is 0 after reset. On each frame_tick it advances by one. When it is at or above period_val, it wraps to 0 instead of advancing.
- R2: start_pulse is high for exactly one cycle. That cycle follows the frame_tick edge at which the counter takes the value start_val, and the block must be armed and ready at that edge.
- R3: No start occurs while every bit of pin_dir_out is 0 (1 means the pin drives output data).
- R4: The buffer-size condition holds only after bufsz_valid has been high for 32 bclk_tick strobes. Dropping bufsz_valid for any cycle restarts that count.
- R5: A fetch is needed when bit 0 or bit 1 of ch_mask_a or ch_mask_b is set. In that case no start occurs while preload_cnt is below 2. When no fetch is needed, preload_cnt is ignored.
- R6: A start_val greater than period_val never produces a start.
- R7: While enable is low, start_pulse, armed and running all stay low.
- R8: Once the start has fired, running stays high, armed stays low and further matches are ignored. This lasts until enable goes low. Raising enable again re-arms the block.
- R9: If readiness arrives after the matching count has passed, the block does not start late. It waits for the next frame where the counter takes start_val.
- R10: After reset, start_pulse, armed and running are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms the trigger while high |
| bclk_tick | input | 1 | One-cycle strobe per bit clock |
| frame_tick | input | 1 | One-cycle strobe per word-clock boundary |
| bufsz_valid | input | 1 | Buffer size has been configured |
| pin_dir_out | input | NUM_PINS (3) | Per data pin, 1 = output |
| ch_mask_a | input | NUM_CH (8) | First word-select channel mask |
| ch_mask_b | input | NUM_CH (8) | Second word-select channel mask |
| preload_cnt | input | PRELOAD_W (2) | Samples already preloaded from memory |
| start_val | input | CNT_W (16) | Frame count at which the stream starts |
| period_val | input | CNT_W (16) | Last counter value before wrap |
| start_pulse | output | 1 | One-shot start |
| armed | output | 1 | Enabled and waiting for the start |
| running | output | 1 | Start has fired |

## Verification
A vector table sets each readiness input one at a time to its failing value and checks that the pulse is withheld. The same table also covers the opposite cases: a mask that needs no fetch with zero preloaded samples, a start value of 0 reached only through a wrap, and a start value above the period. Directed tests then vary inputs over time. They withdraw the enable, deliver readiness just after the match, pulse the buffer-valid flag low part way through the settle count, and re-enable after a start. Comparing the counter value at which the pulse appears against the bench's own frame model distinguishes an on-time start from a late start or one taken off the wrong edge.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } trig_state_e;
endpackage

// File: rtl/ast_wclk_counter.sv
module ast_wclk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [CNT_W-1:0] period_val,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  // wrap once the period value is reached (or passed after a reprogram)
  always_comb begin
    if (cnt_q >= period_val) cnt_nxt = '0;
    else                     cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (frame_tick) cnt_q <= cnt_nxt;
  end

  // compare against the count of the frame that is about to begin
  assign hit = frame_tick && (cnt_nxt == start_val);
  assign cnt = cnt_q;

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && cnt_q >= period_val) |=> (cnt_q == '0));

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(cnt_q));
endmodule

// File: rtl/ast_ready_gate.sv
module ast_ready_gate #(
  parameter int NUM_PINS     = 3,
  parameter int NUM_CH       = 8,
  parameter int FETCH_CH     = 2,
  parameter int SETTLE_TICKS = 32,
  parameter int PRELOAD_W    = 2,
  parameter int PRELOAD_NEED = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_tick,
  input  logic                 bufsz_valid,
  input  logic [NUM_PINS-1:0]  pin_dir_out,
  input  logic [NUM_CH-1:0]    ch_mask_a,
  input  logic [NUM_CH-1:0]    ch_mask_b,
  input  logic [PRELOAD_W-1:0] preload_cnt,
  output logic                 ready
);
  localparam int SET_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [SET_W-1:0]     SETTLE_MAX = SET_W'(SETTLE_TICKS);
  localparam logic [PRELOAD_W-1:0] PRE_MIN    = PRELOAD_W'(PRELOAD_NEED);

  logic [SET_W-1:0]  settle_q;
  logic              settled;
  logic [NUM_CH-1:0] fetch_sel;
  logic              need_fetch;
  logic              preload_ok;
  logic              any_out;

  // channels whose data comes from memory
  for (genvar i = 0; i < NUM_CH; i++) begin : g_fetch_sel
    assign fetch_sel[i] = (i < FETCH_CH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   settle_q <= '0;
    else if (!bufsz_valid)                        settle_q <= '0;
    else if (bclk_tick && settle_q != SETTLE_MAX) settle_q <= settle_q + 1'b1;
  end

  assign settled    = (settle_q == SETTLE_MAX);
  assign need_fetch = |((ch_mask_a | ch_mask_b) & fetch_sel);
  assign preload_ok = !need_fetch || (preload_cnt >= PRE_MIN);
  assign any_out    = |pin_dir_out;
  assign ready      = any_out && settled && preload_ok;

  p_settle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bufsz_valid |=> !settled);

  p_settle_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_tick |=> ($stable(settle_q) || settle_q == '0));
endmodule

// File: rtl/ast_start_fsm.sv
module ast_start_fsm
  import ast_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ready,
  input  logic hit,
  output logic start_pulse,
  output logic armed,
  output logic running
);
  trig_state_e state_q, state_d;
  logic        fire;
  logic        pulse_q;

  assign fire = enable && (state_q == ST_ARMED) && ready && hit;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   state_d = ST_ARMED;
        ST_ARMED: if (fire) state_d = ST_RUN;
        ST_RUN:   state_d = ST_RUN;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= fire;
    end
  end

  assign start_pulse = pulse_q;
  assign armed       = (state_q == ST_ARMED);
  assign running     = (state_q == ST_RUN);

  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_pulse_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> running);

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_pulse && !armed && !running));

  p_run_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable) |=> (running && !start_pulse));
endmodule

// File: rtl/aout_start_trigger.sv
module aout_start_trigger #(
  parameter int CNT_W        = 16,
  parameter int NUM_PINS     = 3,
  parameter int NUM_CH       = 8,
  parameter int FETCH_CH     = 2,
  parameter int SETTLE_TICKS = 32,
  parameter int PRELOAD_W    = 2,
  parameter int PRELOAD_NEED = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 bclk_tick,
  input  logic                 frame_tick,
  input  logic                 bufsz_valid,
  input  logic [NUM_PINS-1:0]  pin_dir_out,
  input  logic [NUM_CH-1:0]    ch_mask_a,
  input  logic [NUM_CH-1:0]    ch_mask_b,
  input  logic [PRELOAD_W-1:0] preload_cnt,
  input  logic [CNT_W-1:0]     start_val,
  input  logic [CNT_W-1:0]     period_val,
  output logic                 start_pulse,
  output logic                 armed,
  output logic                 running
);
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             ready;

  ast_wclk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .period_val (period_val),
    .start_val  (start_val),
    .cnt        (cnt),
    .hit        (hit)
  );

  ast_ready_gate #(
    .NUM_PINS     (NUM_PINS),
    .NUM_CH       (NUM_CH),
    .FETCH_CH     (FETCH_CH),
    .SETTLE_TICKS (SETTLE_TICKS),
    .PRELOAD_W    (PRELOAD_W),
    .PRELOAD_NEED (PRELOAD_NEED)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_tick   (bclk_tick),
    .bufsz_valid (bufsz_valid),
    .pin_dir_out (pin_dir_out),
    .ch_mask_a   (ch_mask_a),
    .ch_mask_b   (ch_mask_b),
    .preload_cnt (preload_cnt),
    .ready       (ready)
  );

  ast_start_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ready       (ready),
    .hit         (hit),
    .start_pulse (start_pulse),
    .armed       (armed),
    .running     (running)
  );

  // the pulse coincides with the counter holding the programmed value
  p_pulse_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (cnt == $past(start_val)));

  p_pulse_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(|pin_dir_out));

  p_pulse_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(start_val) <= $past(period_val)));
endmodule

// File: tb/aout_start_trigger_test.sv
`timescale 1ns/1ps
module aout_start_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bclk_tick = 1'b0;
  logic        frame_tick = 1'b0;
  logic        bufsz_valid = 1'b0;
  logic [2:0]  pin_dir_out = '0;
  logic [7:0]  ch_mask_a = '0;
  logic [7:0]  ch_mask_b = '0;
  logic [1:0]  preload_cnt = '0;
  logic [15:0] start_val = '0;
  logic [15:0] period_val = '0;
  logic        start_pulse, armed, running;

  int total = 0;
  int bad = 0;
  int mc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aout_start_trigger uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_tick(bclk_tick),
    .frame_tick(frame_tick), .bufsz_valid(bufsz_valid),
    .pin_dir_out(pin_dir_out), .ch_mask_a(ch_mask_a), .ch_mask_b(ch_mask_b),
    .preload_cnt(preload_cnt), .start_val(start_val), .period_val(period_val),
    .start_pulse(start_pulse), .armed(armed), .running(running)
  );

  typedef struct packed {
    logic [15:0] sv;
    logic [15:0] pv;
    logic [2:0]  pins;
    logic [7:0]  ma;
    logic [7:0]  mb;
    logic [1:0]  pre;
    logic [5:0]  ticks;
    logic        fire;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd3, 16'd7, 3'b001, 8'h01, 8'h00, 2'd2, 6'd32, 1'b1}, // R2 baseline
    '{16'd3, 16'd7, 3'b000, 8'h01, 8'h00, 2'd2, 6'd32, 1'b0}, // R3 no output pin
    '{16'd3, 16'd7, 3'b010, 8'h01, 8'h00, 2'd2, 6'd31, 1'b0}, // R4 one tick short
    '{16'd3, 16'd7, 3'b001, 8'h01, 8'h00, 2'd1, 6'd32, 1'b0}, // R5 one sample short
    '{16'd5, 16'd6, 3'b001, 8'h10, 8'h00, 2'd0, 6'd32, 1'b1}, // R5 no fetch needed
    '{16'd9, 16'd7, 3'b001, 8'h01, 8'h00, 2'd2, 6'd32, 1'b0}, // R6 beyond period
    '{16'd0, 16'd4, 3'b001, 8'h02, 8'h00, 2'd2, 6'd40, 1'b1}, // R1 start at wrap
    '{16'd7, 16'd7, 3'b100, 8'h00, 8'h02, 2'd3, 6'd32, 1'b1}  // R2 top count
  };

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; bufsz_valid = 1'b0;
    frame_tick = 1'b0; bclk_tick = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    mc = 0;
    @(negedge clk);
  endtask

  task automatic bclk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bclk_tick = 1'b1;
      @(negedge clk) bclk_tick = 1'b0;
    end
  endtask

  // one frame: strobe, then read the pulse in the cycle after the edge and the one after that
  task automatic run_frame(output bit hit, output bit extra);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    hit = start_pulse;
    mc = (mc >= int'(period_val)) ? 0 : mc + 1;
    @(negedge clk) extra = start_pulse;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit h, x;
    int np, at, nx;

    // R10 reset state
    do_reset();
    chk(start_pulse == 1'b0 && armed == 1'b0 && running == 1'b0, "R10 reset outputs",
        {start_pulse, armed, running}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      start_val = VECS[v].sv; period_val = VECS[v].pv;
      pin_dir_out = VECS[v].pins; ch_mask_a = VECS[v].ma; ch_mask_b = VECS[v].mb;
      preload_cnt = VECS[v].pre;
      bufsz_valid = 1'b1;
      bclk(int'(VECS[v].ticks));
      enable = 1'b1;
      @(negedge clk);
      chk(armed == 1'b1, "R8 armed after enable", armed, 1);
      np = 0; at = -1; nx = 0;
      for (int f = 0; f < 2 * (int'(VECS[v].pv) + 1) + 2; f++) begin
        run_frame(h, x);
        if (h) begin np++; at = mc; end
        if (x) nx++;
      end
      chk(np == (VECS[v].fire ? 1 : 0), $sformatf("R2 pulse count vec%0d", v), np, VECS[v].fire ? 1 : 0);
      if (VECS[v].fire)
        chk(at == int'(VECS[v].sv), $sformatf("R1 pulse count value vec%0d", v), at, int'(VECS[v].sv));
      chk(nx == 0, $sformatf("R2 single cycle vec%0d", v), nx, 0);
      chk(running == VECS[v].fire, $sformatf("R8 running vec%0d", v), running, VECS[v].fire);
    end

    // R7 disabled: never fires even though ready
    do_reset();
    start_val = 16'd2; period_val = 16'd4;
    pin_dir_out = 3'b001; ch_mask_a = 8'h01; ch_mask_b = 8'h00; preload_cnt = 2'd2;
    bufsz_valid = 1'b1; bclk(32);
    np = 0;
    for (int f = 0; f < 12; f++) begin
      run_frame(h, x);
      if (h || x || armed || running) np++;
    end
    chk(np == 0, "R7 disabled stays quiet", np, 0);

    // R9 readiness arrives after the match has passed
    do_reset();
    start_val = 16'd2; period_val = 16'd5;
    pin_dir_out = 3'b001; ch_mask_a = 8'h01; ch_mask_b = 8'h00; preload_cnt = 2'd0;
    bufsz_valid = 1'b1; bclk(32);
    enable = 1'b1; @(negedge clk);
    np = 0;
    for (int f = 0; f < 3; f++) begin
      run_frame(h, x);
      if (h) np++;
    end
    chk(np == 0, "R5 no start without preload", np, 0);
    preload_cnt = 2'd2;
    np = 0; at = -1;
    for (int f = 0; f < 5; f++) begin
      run_frame(h, x);
      if (h) begin np++; at = mc; end
    end
    chk(np == 1, "R9 single late-ready start", np, 1);
    chk(at == 2, "R9 waits for next matching count", at, 2);

    // R8 later matches ignored
    np = 0;
    for (int f = 0; f < 14; f++) begin
      run_frame(h, x);
      if (h || x) np++;
    end
    chk(np == 0, "R8 no repeat start", np, 0);
    chk(running == 1'b1 && armed == 1'b0, "R8 running held", {running, armed}, 2);

    // R8 disable then re-arm
    enable = 1'b0; @(negedge clk);
    chk(running == 1'b0 && armed == 1'b0, "R7 disable clears status", {running, armed}, 0);
    enable = 1'b1; @(negedge clk);
    chk(armed == 1'b1, "R8 re-armed", armed, 1);
    np = 0; at = -1;
    for (int f = 0; f < 7; f++) begin
      run_frame(h, x);
      if (h) begin np++; at = mc; end
    end
    chk(np == 1 && at == 2, "R8 fires again after re-arm", at, 2);

    // R4 dropping the valid flag restarts the settle count
    do_reset();
    start_val = 16'd1; period_val = 16'd3;
    pin_dir_out = 3'b001; ch_mask_a = 8'h00; ch_mask_b = 8'h01; preload_cnt = 2'd2;
    bufsz_valid = 1'b1; bclk(20);
    bufsz_valid = 1'b0; @(negedge clk);
    bufsz_valid = 1'b1; bclk(31);
    enable = 1'b1; @(negedge clk);
    np = 0;
    for (int f = 0; f < 9; f++) begin
      run_frame(h, x);
      if (h) np++;
    end
    chk(np == 0, "R4 restart after valid drop", np, 0);
    bclk(1);
    np = 0; at = -1;
    for (int f = 0; f < 5; f++) begin
      run_frame(h, x);
      if (h) begin np++; at = mc; end
    end
    chk(np == 1 && at == 1, "R4 starts once settled", at, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule